// File: doc/BRIEF.md
# Three-Bit Pixel Bus Decoder

This block sits at the receiving end of a narrow pixel bus. The video fetch engine sends it one 3-bit code per color clock. The decoder turns each code into two half-clock pixel classes: background, or one of four playfields. It also raises flags for vertical sync and horizontal blank. A high-resolution state is held inside the block. That state is set or cleared by the two blank codes, and it changes how playfield codes are read. In high resolution each playfield code carries two half-width pixels that differ only in luminance. A separate pairing path joins consecutive playfield codes into 4-bit pixel values for the nibble-per-pixel display modes.

The decoder finds the start of each scanline from the bus alone: a blank code that follows a non-blank code marks it. From that point it counts color clocks. At fixed slot offsets it samples the system data bus into one missile byte and four player bytes, each with a one-cycle strobe. It does not check whether memory fetches were actually made on those cycles. If graphics capture is enabled but no fetch happened, the byte captured is whatever value the data bus held.

Every output is registered. Each one reflects the code presented on the previous clock.

Top module: `pixbus_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero: both pixel classes are background (0), hires_o, lum_only_o, vsync_o, hblank_o, line_start_o, nib_valid_o, the strobes and the captured bytes all read 0.
- R2: The pixel classes are encoded as background=0, PF0=1, PF1=2, PF2=3, PF3=4. Outside high-resolution mode, code 000 gives background and code 1ab gives playfield ab on both half pixels. Both half pixels are always equal in this mode. All outputs appear one clock after the code.
- R3: Code 001 raises vsync_o and gives background on both half pixels, with hblank_o low.
- R4: Codes 010 and 011 raise hblank_o and give background pixels. Code 010 clears the high-resolution state and code 011 sets it. The state, visible on hires_o, holds through all other codes until the next blank code.
- R5: In high-resolution mode, code 1ab gives a left half pixel from bit a and a right half pixel from bit b. A bit of 1 gives PF1 and a bit of 0 gives PF2. lum_only_o is high for such codes.
- R6: With nib_mode_i high, consecutive playfield codes are taken in pairs. The first code supplies nib_o[3:2] and the second supplies nib_o[1:0]. nib_valid_o pulses after the second code. Any non-playfield code, or nib_mode_i low, restarts the pairing.
- R7: A blank code (010 or 011) whose preceding code was not a blank code is a line start, and line_start_o pulses. A blank code that directly follows a blank code is not a line start.
- R8: With pm_en_i high, the data-bus byte present in the cycle MSL_SLOT (default 4) clocks after a line-start code is captured to msl_byte_o, and msl_stb_o pulses.
- R9: With pm_en_i high, player n (n = 0 to 3) is captured to plr_bytes_o[8n+7:8n] from the cycle PLR_SLOT0 + 2n (default 8, 10, 12, 14) clocks after the line start, and plr_stb_o[n] pulses.
- R10: With pm_en_i low, no strobe fires and the captured bytes keep their old values.
- R11: No capture happens before the first line start after reset. Once LINE_LEN (default 228) clocks pass with no new line start, the slot counter saturates and no slot fires again until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color-clock rate clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 3 | Pixel bus code, one per clock |
| dbus_i | input | 8 | System data bus, sampled at graphics slots |
| pm_en_i | input | 1 | Enables capture of player/missile bytes |
| nib_mode_i | input | 1 | Enables pairing of codes into 4-bit pixels |
| pix_left_o | output | 3 | Class of the left half pixel |
| pix_right_o | output | 3 | Class of the right half pixel |
| lum_only_o | output | 1 | High-resolution luminance-only pixel pair |
| hires_o | output | 1 | Current high-resolution state |
| vsync_o | output | 1 | Vertical sync code seen |
| hblank_o | output | 1 | Horizontal blank code seen |
| line_start_o | output | 1 | Scanline start detected |
| nib_o | output | 4 | Assembled 4-bit pixel |
| nib_valid_o | output | 1 | nib_o holds a completed pair |
| msl_stb_o | output | 1 | Missile byte captured |
| msl_byte_o | output | 8 | Captured missile byte |
| plr_stb_o | output | 4 | Player byte n captured |
| plr_bytes_o | output | 32 | Captured player bytes, player n at bits 8n+7:8n |

## Verification
The assertions assume that the mode inputs and the data bus change only between clock edges. They also assume that reset is held for at least one edge before any code counts. The properties that refer to the previous input code rely on this. The bench drives every input on the falling edge, asserts reset at the start of each scenario, and changes nib_mode_i and pm_en_i only inside reset or between whole lines. That keeps each pairing and each slot window inside one setting. The bench sends a sync code ahead of every line start it creates, so that the line-start timing is always set deliberately.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    typedef enum logic [2:0] {
        CLS_BG  = 3'd0,
        CLS_PF0 = 3'd1,
        CLS_PF1 = 3'd2,
        CLS_PF2 = 3'd3,
        CLS_PF3 = 3'd4
    } pix_cls_t;

    typedef struct packed {
        logic       is_pf;
        logic       is_sync;
        logic       is_blank;
        logic       hires_set;
        logic [1:0] sel;
    } code_info_t;

    localparam int N_PLAYERS = 4;
    localparam int N_SLOTS   = N_PLAYERS + 1;

    function automatic code_info_t decode_code(input logic [2:0] c);
        code_info_t r;
        r.is_pf     = c[2];
        r.is_sync   = (c == 3'b001);
        r.is_blank  = (c[2:1] == 2'b01);
        r.hires_set = c[0];
        r.sel       = c[1:0];
        return r;
    endfunction

    function automatic pix_cls_t pf_class(input logic [1:0] sel);
        pix_cls_t r;
        case (sel)
            2'd0:    r = CLS_PF0;
            2'd1:    r = CLS_PF1;
            2'd2:    r = CLS_PF2;
            default: r = CLS_PF3;
        endcase
        return r;
    endfunction

    function automatic pix_cls_t luma_class(input logic lit);
        return lit ? CLS_PF1 : CLS_PF2;
    endfunction

endpackage

// File: rtl/pbd_hires_track.sv
module pbd_hires_track
    import pbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  code_info_t info,
    output logic       hires_now,
    output logic       hires_q
);
    assign hires_now = info.is_blank ? info.hires_set : hires_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hires_q <= 1'b0;
        end else begin
            hires_q <= hires_now;
        end
    end
endmodule

// File: rtl/pbd_half_expand.sv
module pbd_half_expand
    import pbd_pkg::*;
(
    input  code_info_t info,
    input  logic       hires,
    output pix_cls_t   left,
    output pix_cls_t   right,
    output logic       lum_only
);
    always_comb begin
        left     = CLS_BG;
        right    = CLS_BG;
        lum_only = 1'b0;
        if (info.is_pf) begin
            if (hires) begin
                left     = luma_class(info.sel[1]);
                right    = luma_class(info.sel[0]);
                lum_only = 1'b1;
            end else begin
                left  = pf_class(info.sel);
                right = pf_class(info.sel);
            end
        end
    end
endmodule

// File: rtl/pbd_nibble_pair.sv
module pbd_nibble_pair
    import pbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  code_info_t info,
    output logic [3:0] nib_nx,
    output logic       valid_nx
);
    logic       second_q;
    logic [1:0] upper_q;

    assign valid_nx = enable && info.is_pf && second_q;
    assign nib_nx   = {upper_q, info.sel};

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
            upper_q  <= '0;
        end else if (!enable || !info.is_pf) begin
            second_q <= 1'b0;
        end else begin
            second_q <= ~second_q;
            if (!second_q) begin
                upper_q <= info.sel;
            end
        end
    end
endmodule

// File: rtl/pbd_slot_timer.sv
module pbd_slot_timer
    import pbd_pkg::*;
#(
    parameter int LINE_LEN   = 228,
    parameter int MSL_SLOT   = 4,
    parameter int PLR_SLOT0  = 8,
    parameter int PLR_STRIDE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  code_info_t         info,
    input  logic               pm_en,
    output logic               start_nx,
    output logic [N_SLOTS-1:0] slot_hit
);
    localparam int CW = $clog2(LINE_LEN + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LINE_LEN);

    logic          prev_blank_q;
    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] pos_now;
    logic          armed_now;

    assign start_nx  = info.is_blank && !prev_blank_q;
    assign armed_now = start_nx || armed_q;
    assign pos_now   = start_nx ? '0 : cnt_q;

    genvar s;
    generate
        for (s = 0; s < N_SLOTS; s++) begin : g_slot
            localparam int OFS = (s == 0) ? MSL_SLOT : PLR_SLOT0 + (s - 1) * PLR_STRIDE;
            assign slot_hit[s] = pm_en && armed_now && (pos_now == CW'(OFS));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_blank_q <= 1'b1;
            armed_q      <= 1'b0;
            cnt_q        <= CNT_MAX;
        end else begin
            prev_blank_q <= info.is_blank;
            armed_q      <= armed_now;
            if (pos_now != CNT_MAX) begin
                cnt_q <= pos_now + 1'b1;
            end else begin
                cnt_q <= CNT_MAX;
            end
        end
    end
endmodule

// File: rtl/pixbus_decoder.sv
module pixbus_decoder
    import pbd_pkg::*;
#(
    parameter int LINE_LEN   = 228,
    parameter int MSL_SLOT   = 4,
    parameter int PLR_SLOT0  = 8,
    parameter int PLR_STRIDE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  code_i,
    input  logic [7:0]  dbus_i,
    input  logic        pm_en_i,
    input  logic        nib_mode_i,
    output logic [2:0]  pix_left_o,
    output logic [2:0]  pix_right_o,
    output logic        lum_only_o,
    output logic        hires_o,
    output logic        vsync_o,
    output logic        hblank_o,
    output logic        line_start_o,
    output logic [3:0]  nib_o,
    output logic        nib_valid_o,
    output logic        msl_stb_o,
    output logic [7:0]  msl_byte_o,
    output logic [3:0]  plr_stb_o,
    output logic [31:0] plr_bytes_o
);
    code_info_t         info;
    logic               hires_now;
    logic               hires_q;
    pix_cls_t           left_nx;
    pix_cls_t           right_nx;
    logic               lum_nx;
    logic [3:0]         nib_nx;
    logic               nib_v_nx;
    logic               start_nx;
    logic [N_SLOTS-1:0] slot_hit;

    assign info    = decode_code(code_i);
    assign hires_o = hires_q;

    pbd_hires_track u_hires (
        .clk       (clk),
        .rst       (rst),
        .info      (info),
        .hires_now (hires_now),
        .hires_q   (hires_q)
    );

    pbd_half_expand u_expand (
        .info     (info),
        .hires    (hires_now),
        .left     (left_nx),
        .right    (right_nx),
        .lum_only (lum_nx)
    );

    pbd_nibble_pair u_nib (
        .clk      (clk),
        .rst      (rst),
        .enable   (nib_mode_i),
        .info     (info),
        .nib_nx   (nib_nx),
        .valid_nx (nib_v_nx)
    );

    pbd_slot_timer #(
        .LINE_LEN   (LINE_LEN),
        .MSL_SLOT   (MSL_SLOT),
        .PLR_SLOT0  (PLR_SLOT0),
        .PLR_STRIDE (PLR_STRIDE)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .info     (info),
        .pm_en    (pm_en_i),
        .start_nx (start_nx),
        .slot_hit (slot_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_left_o   <= CLS_BG;
            pix_right_o  <= CLS_BG;
            lum_only_o   <= 1'b0;
            vsync_o      <= 1'b0;
            hblank_o     <= 1'b0;
            line_start_o <= 1'b0;
            nib_o        <= '0;
            nib_valid_o  <= 1'b0;
            msl_stb_o    <= 1'b0;
            msl_byte_o   <= '0;
        end else begin
            pix_left_o   <= left_nx;
            pix_right_o  <= right_nx;
            lum_only_o   <= lum_nx;
            vsync_o      <= info.is_sync;
            hblank_o     <= info.is_blank;
            line_start_o <= start_nx;
            nib_valid_o  <= nib_v_nx;
            if (nib_v_nx) begin
                nib_o <= nib_nx;
            end
            msl_stb_o <= slot_hit[0];
            if (slot_hit[0]) begin
                msl_byte_o <= dbus_i;
            end
        end
    end

    genvar p;
    generate
        for (p = 0; p < N_PLAYERS; p++) begin : g_plr
            always_ff @(posedge clk) begin
                if (rst) begin
                    plr_stb_o[p]         <= 1'b0;
                    plr_bytes_o[8*p +: 8] <= '0;
                end else begin
                    plr_stb_o[p] <= slot_hit[p+1];
                    if (slot_hit[p+1]) begin
                        plr_bytes_o[8*p +: 8] <= dbus_i;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  code_i,
    input logic        pm_en_i,
    input logic        nib_mode_i,
    input logic [2:0]  pix_left_o,
    input logic [2:0]  pix_right_o,
    input logic        hires_o,
    input logic        vsync_o,
    input logic        hblank_o,
    input logic        line_start_o,
    input logic        nib_valid_o,
    input logic        msl_stb_o,
    input logic [3:0]  plr_stb_o
);
    // R2: normal resolution keeps both halves equal
    a_r2_halves_equal: assert property (@(posedge clk) disable iff (rst)
        ($past(code_i[2]) && !hires_o) |-> (pix_left_o == pix_right_o));

    // R3: sync gives background and no blank
    a_r3_sync_bg: assert property (@(posedge clk) disable iff (rst)
        vsync_o |-> (pix_left_o == 3'd0 && pix_right_o == 3'd0 && !hblank_o));

    // R4: hires state only moves on a blank code
    a_r4_hires_on_blank: assert property (@(posedge clk) disable iff (rst)
        (hires_o != $past(hires_o)) |-> hblank_o);

    // R7: line start is a blank after a non-blank
    a_r7_start_edge: assert property (@(posedge clk) disable iff (rst)
        line_start_o |-> (hblank_o && !$past(hblank_o)));

    // R9: at most one capture slot per cycle
    a_r9_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({plr_stb_o, msl_stb_o}));

    // R10: no capture without enable
    a_r10_no_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(pm_en_i) |-> (plr_stb_o == 4'd0 && !msl_stb_o));

    // R6: a completed pair needs two playfield codes in nibble mode
    a_r6_pair_src: assert property (@(posedge clk) disable iff (rst)
        nib_valid_o |-> ($past(code_i[2]) && $past(nib_mode_i) && $past(code_i[2], 2)));
endmodule

bind pixbus_decoder pbd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .code_i       (code_i),
    .pm_en_i      (pm_en_i),
    .nib_mode_i   (nib_mode_i),
    .pix_left_o   (pix_left_o),
    .pix_right_o  (pix_right_o),
    .hires_o      (hires_o),
    .vsync_o      (vsync_o),
    .hblank_o     (hblank_o),
    .line_start_o (line_start_o),
    .nib_valid_o  (nib_valid_o),
    .msl_stb_o    (msl_stb_o),
    .plr_stb_o    (plr_stb_o)
);

// File: tb/sim_pixbus_decoder.sv
module sim_pixbus_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  code_i;
    logic [7:0]  dbus_i;
    logic        pm_en_i;
    logic        nib_mode_i;
    logic [2:0]  pix_left_o;
    logic [2:0]  pix_right_o;
    logic        lum_only_o;
    logic        hires_o;
    logic        vsync_o;
    logic        hblank_o;
    logic        line_start_o;
    logic [3:0]  nib_o;
    logic        nib_valid_o;
    logic        msl_stb_o;
    logic [7:0]  msl_byte_o;
    logic [3:0]  plr_stb_o;
    logic [31:0] plr_bytes_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pixbus_decoder u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk);
        code_i = c;
        dbus_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic pm, input logic nm);
        @(negedge clk);
        rst        = 1'b1;
        code_i     = 3'b000;
        dbus_i     = 8'h00;
        pm_en_i    = pm;
        nib_mode_i = nm;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b1);
        chk("R1", "left", pix_left_o, 0);
        chk("R1", "right", pix_right_o, 0);
        chk("R1", "flags", {hires_o, lum_only_o, vsync_o, hblank_o, line_start_o, nib_valid_o}, 0);
        chk("R1", "strobes", {plr_stb_o, msl_stb_o}, 0);
        chk("R1", "bytes", int'(plr_bytes_o) | int'(msl_byte_o), 0);
    endtask

    task automatic t_plain();
        do_reset(1'b0, 1'b0);
        step(3'b000, 8'h00);
        chk("R2", "bg left", pix_left_o, 0);
        chk("R2", "bg right", pix_right_o, 0);
        for (int k = 0; k < 4; k++) begin
            step(3'(4 + k), 8'h00);
            chk("R2", "pf left", pix_left_o, k + 1);
            chk("R2", "pf right", pix_right_o, k + 1);
            chk("R2", "lum low", lum_only_o, 0);
        end
        step(3'b001, 8'h00);
        chk("R3", "vsync", vsync_o, 1);
        chk("R3", "sync pixel", pix_left_o, 0);
        chk("R3", "no blank", hblank_o, 0);
    endtask

    task automatic t_hires();
        do_reset(1'b0, 1'b0);
        step(3'b011, 8'h00);
        chk("R4", "hblank", hblank_o, 1);
        chk("R4", "hires set", hires_o, 1);
        step(3'b110, 8'h00);
        chk("R5", "left lit", pix_left_o, 2);
        chk("R5", "right dark", pix_right_o, 3);
        chk("R5", "lum", lum_only_o, 1);
        step(3'b001, 8'h00);
        step(3'b000, 8'h00);
        chk("R4", "hires held", hires_o, 1);
        step(3'b101, 8'h00);
        chk("R5", "left dark", pix_left_o, 3);
        chk("R5", "right lit", pix_right_o, 2);
        step(3'b010, 8'h00);
        chk("R4", "hires cleared", hires_o, 0);
        chk("R4", "blank pixel", pix_left_o, 0);
        step(3'b101, 8'h00);
        chk("R2", "normal again", pix_right_o, 2);
        chk("R2", "lum off", lum_only_o, 0);
    endtask

    task automatic t_nibble();
        do_reset(1'b0, 1'b1);
        step(3'b110, 8'h00);
        chk("R6", "first no valid", nib_valid_o, 0);
        step(3'b101, 8'h00);
        chk("R6", "pair valid", nib_valid_o, 1);
        chk("R6", "pair value", nib_o, 9);
        step(3'b111, 8'h00);
        step(3'b000, 8'h00);
        chk("R6", "break no valid", nib_valid_o, 0);
        step(3'b100, 8'h00);
        chk("R6", "restart first", nib_valid_o, 0);
        step(3'b111, 8'h00);
        chk("R6", "restart value", nib_o, 3);
        chk("R6", "restart valid", nib_valid_o, 1);
    endtask

    task automatic run_line(input logic expect_on, input string req);
        step(3'b001, 8'h00);
        step(3'b010, 8'h11);
        chk("R7", "line start", line_start_o, 1);
        step(3'b010, 8'h12);
        chk("R7", "second blank", line_start_o, 0);
        for (int i = 2; i < 20; i++) begin
            logic ms;
            logic [3:0] ps;
            step(3'b000, 8'hA0 + 8'(i));
            ms = expect_on && (i == 4);
            ps = '0;
            for (int p = 0; p < 4; p++) begin
                if (expect_on && i == 8 + 2 * p) ps[p] = 1'b1;
            end
            chk(req, "msl strobe", msl_stb_o, ms);
            chk(req, "plr strobe", plr_stb_o, ps);
        end
    endtask

    task automatic t_capture();
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            step(3'b100, 8'h55);
            chk("R11", "no capture before start", {plr_stb_o, msl_stb_o}, 0);
        end
        run_line(1'b1, "R8");
        chk("R8", "missile byte", msl_byte_o, 8'hA4);
        chk("R9", "player bytes", plr_bytes_o, 32'hAEACAAA8);
        for (int i = 0; i < 260; i++) begin
            step(3'b000, 8'h77);
            chk("R11", "saturated", {plr_stb_o, msl_stb_o}, 0);
        end
        do_reset(1'b1, 1'b0);
        pm_en_i = 1'b0;
        run_line(1'b0, "R10");
        chk("R10", "missile held", msl_byte_o, 0);
        chk("R10", "players held", plr_bytes_o, 0);
    endtask

    initial begin
        rst = 1'b1;
        code_i = 3'b000;
        dbus_i = 8'h00;
        pm_en_i = 1'b0;
        nib_mode_i = 1'b0;
        t_reset();
        t_plain();
        t_hires();
        t_nibble();
        t_capture();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule